// File: doc/BRIEF.md
# Two-Phase Dead-Time Commutation Sequencer

This block turns a rotor-position polarity signal into the drive enables for a two-phase, half-wave brushless fan motor. One polarity of the position signal selects phase 1, the other selects phase 2. The position signal arrives asynchronously. It is brought into the clock domain, and every change of its synchronized value starts a fixed blanking interval. During that interval neither phase may conduct, so the outgoing coil has released before the incoming coil switches on.

The selected phase is further gated by a PWM drive enable and by a disable input from the protection logic. A tachometer/lock status output tracks the synchronized rotor polarity while the motor runs. It is held high whenever the disable input is asserted. The dead time is a parameter counted in clock cycles, so a 40 µs interval at 100 MHz is 4000 cycles.

Top module: `phase_commutator`

## Requirements
- R1: Outside the dead interval, with `pwm_en` high and `fault_off` low, `hall_pol` = 1 drives `ph1_on` = 1 and `ph2_on` = 0, and `hall_pol` = 0 drives `ph2_on` = 1 and `ph1_on` = 0.
- R2: A change on `hall_pol` set up before clock edge P0 reaches the synchronized value at P1. Both phase outputs are 0 from edge P2 on, and the newly selected phase turns on at edge P2+DEAD_CYCLES, so both phases are off for exactly DEAD_CYCLES cycles.
- R3: `ph1_on` and `ph2_on` are never 1 in the same cycle.
- R4: A change of the synchronized polarity that arrives while a dead interval is running restarts the interval. The new phase turns on DEAD_CYCLES cycles after the restart, not after the first edge.
- R5: `pwm_en` = 0 forces both phase outputs to 0 at the next clock edge, and `pwm_en` = 1 restores the selected phase at the next edge. The dead interval counts independently of `pwm_en`.
- R6: `fault_off` = 1 forces both phase outputs to 0 at the next clock edge.
- R7: `tach_out` equals the synchronized polarity (same P2 latency as R2) while `fault_off` is 0, and is 1 from the next edge on while `fault_off` is 1.
- R8: During synchronous reset (`rst_n` = 0) both phases are 0 and `tach_out` is 1. A dead interval is armed by reset, so after release with `hall_pol` = 0 the phases stay off for DEAD_CYCLES-1 edges and `ph2_on` turns on at the DEAD_CYCLES-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_pol | input | 1 | Asynchronous rotor polarity (1 selects phase 1) |
| pwm_en | input | 1 | PWM drive enable |
| fault_off | input | 1 | Disable from the protection logic |
| ph1_on | output | 1 | Phase 1 drive enable |
| ph2_on | output | 1 | Phase 2 drive enable |
| tach_out | output | 1 | Tachometer / lock status, high during fault |

## Verification
The bench times a polarity change edge by edge. It confirms that the old phase is still on through the synchronizer latency, that both phases drop together, and that the new phase appears exactly DEAD_CYCLES edges later. A design with an off-by-one counter would turn the phase on one cycle early or late. A polarity reversal during the dead interval is checked for a restarted blanking window; a design that ignored the second edge would switch on at the first edge's deadline. Further checks cover the fault input holding `tach_out` high even as the polarity falls, which a design that only gated the phases would miss, and the interval armed by reset, which a design would skip by driving phase 2 immediately.

// File: rtl/comm_pkg.sv
// Shared types for the commutation sequencer.
package comm_pkg;
    // Phase chosen by the synchronized rotor polarity
    typedef enum logic {
        PH_TWO = 1'b0,
        PH_ONE = 1'b1
    } phase_e;
endpackage

// File: rtl/pol_sync.sv
// Two-flop synchronizer for the rotor polarity plus change detector.
// Assumes: pol_async may change at any time. chg_o is high for one cycle
// after each change of the synchronized value pol_o.
module pol_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_async,
    output logic pol_o,
    output logic chg_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchronize the polarity and keep last cycle's value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pol_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Change flag and synchronized polarity
    always_comb begin
        pol_o = sync_q;
        chg_o = sync_q ^ prev_q;
    end
endmodule

// File: rtl/blank_timer.sv
// Dead-interval timer. Any polarity change (re)loads the counter.
// blank_o is high while the change is pending or the counter is nonzero.
// Assumes: DEAD_CYCLES >= 1. Reset arms a full interval.
module blank_timer #(
    parameter int DEAD_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    output logic blank_o
);
    localparam int CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYCLES - 1);

    logic [CW-1:0] left_q;

    // Reload on every change, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= LOAD;
        end else if (chg_i) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Blanking request seen by the output stage
    always_comb begin
        blank_o = chg_i || (left_q != '0);
    end

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (left_q == LOAD));
endmodule

// File: rtl/drive_gate.sv
// Output stage: registers the phase enables and the tach/lock output.
// Assumes: blank_i covers every polarity change (see blank_timer).
module drive_gate
    import comm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pol_i,
    input  logic blank_i,
    input  logic pwm_en,
    input  logic fault_off,
    output logic ph1_on,
    output logic ph2_on,
    output logic tach_out
);
    phase_e sel;
    logic   run;

    // Phase choice and overall permission to conduct
    always_comb begin
        sel = phase_e'(pol_i);
        run = pwm_en && !fault_off && !blank_i;
    end

    // Register drive enables and status output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph1_on   <= 1'b0;
            ph2_on   <= 1'b0;
            tach_out <= 1'b1;
        end else begin
            ph1_on   <= run && (sel == PH_ONE);
            ph2_on   <= run && (sel == PH_TWO);
            tach_out <= fault_off || pol_i;
        end
    end

    // R1
    sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph1_on |-> $past(pol_i));
    // R2
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> (!ph1_on && !ph2_on));
    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph1_on && ph2_on));
    // R5
    pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> (!ph1_on && !ph2_on));
    // R6
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_off |=> (!ph1_on && !ph2_on));
    // R7
    fault_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_off |=> tach_out);
endmodule

// File: rtl/phase_commutator.sv
// Two-phase half-wave commutation sequencer with fixed dead time.
// Assumes: hall_pol is asynchronous, pwm_en and fault_off are synchronous
// to clk. DEAD_CYCLES is the dead time in clock cycles (>= 1).
module phase_commutator #(
    parameter int DEAD_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_pol,
    input  logic pwm_en,
    input  logic fault_off,
    output logic ph1_on,
    output logic ph2_on,
    output logic tach_out
);
    logic pol_s;
    logic pol_chg;
    logic blank;

    pol_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pol_async (hall_pol),
        .pol_o     (pol_s),
        .chg_o     (pol_chg)
    );

    blank_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg_i   (pol_chg),
        .blank_o (blank)
    );

    drive_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pol_i     (pol_s),
        .blank_i   (blank),
        .pwm_en    (pwm_en),
        .fault_off (fault_off),
        .ph1_on    (ph1_on),
        .ph2_on    (ph2_on),
        .tach_out  (tach_out)
    );
endmodule

// File: tb/phase_commutator_test.sv
module phase_commutator_test;
    localparam int D = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hall_pol = 1'b0;
    logic pwm_en = 1'b1;
    logic fault_off = 1'b0;
    logic ph1_on, ph2_on, tach_out;
    int   n_run = 0;
    int   n_fail = 0;
    bit   overlap_seen = 1'b0;

    always #5 clk = ~clk;

    phase_commutator #(.DEAD_CYCLES(D)) uut (
        .clk(clk), .rst_n(rst_n), .hall_pol(hall_pol), .pwm_en(pwm_en),
        .fault_off(fault_off), .ph1_on(ph1_on), .ph2_on(ph2_on),
        .tach_out(tach_out)
    );

    // Fields: hall, pwm, fault, wait[3:0], exp ph1, exp ph2, exp tach
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        {3'b010, 4'd1, 3'b010},  // R1 steady phase 2
        {3'b110, 4'd1, 3'b010},  // R2 first sync stage, old phase holds
        {3'b110, 4'd1, 3'b010},  // R2 second sync stage, old phase holds
        {3'b110, 4'd1, 3'b001},  // R2 both off, R7 tach follows
        {3'b110, 4'd5, 3'b001},  // R2 still blanked at P(D+1)
        {3'b110, 4'd1, 3'b101},  // R1 phase 1 on at P(D+2)
        {3'b100, 4'd1, 3'b001},  // R5 pwm low gates off
        {3'b110, 4'd1, 3'b101},  // R5 pwm high restores
        {3'b111, 4'd1, 3'b001},  // R6 fault forces off
        {3'b011, 4'd3, 3'b001},  // R7 tach held high though polarity fell
        {3'b010, 4'd1, 3'b000},  // R7 tach follows again, still blanked
        {3'b010, 4'd5, 3'b010}   // R2 phase 2 on at P(D+2)
    };

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got ph1/ph2/tach=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    always @(negedge clk) if (ph1_on && ph2_on) overlap_seen = 1'b1;

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit saw_ph1;
        @(negedge clk);
        wait_edges(2);
        check("R8 reset state", {ph1_on, ph2_on, tach_out}, 3'b001);
        rst_n = 1'b1;
        wait_edges(D + 4);
        check("R1 settled phase 2", {ph1_on, ph2_on, tach_out}, 3'b010);

        // table walk
        for (int i = 0; i < NV; i++) begin
            hall_pol  = VEC[i][9];
            pwm_en    = VEC[i][8];
            fault_off = VEC[i][7];
            wait_edges(int'(VEC[i][6:3]));
            check($sformatf("table %0d", i), {ph1_on, ph2_on, tach_out}, VEC[i][2:0]);
        end

        // R4: reversal during the dead interval restarts it
        hall_pol = 1'b1;
        wait_edges(4);
        check("R4 blanked after first edge", {ph1_on, ph2_on, tach_out}, 3'b001);
        hall_pol = 1'b0;
        saw_ph1 = 1'b0;
        for (int k = 0; k < D + 2; k++) begin
            @(negedge clk);
            if (ph1_on || ph2_on) saw_ph1 = 1'b1;
        end
        check("R4 no phase during restarted interval", {2'b00, saw_ph1}, 3'b000);
        wait_edges(1);
        check("R4 phase 2 on after restart", {ph1_on, ph2_on, tach_out}, 3'b010);

        // R8: interval armed by reset
        rst_n = 1'b0;
        wait_edges(2);
        check("R8 reset forces off, tach high", {ph1_on, ph2_on, tach_out}, 3'b001);
        rst_n = 1'b1;
        wait_edges(D - 1);
        check("R8 still off D-1 edges after release", {ph1_on, ph2_on}, 3'b000 >> 1);
        wait_edges(1);
        check("R8 phase 2 on at edge D", {ph1_on, ph2_on, tach_out}, 3'b010);

        check("R3 phases never overlapped", {2'b00, overlap_seen}, 3'b000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule